// File: doc/BRIEF.md
# MII Management Register Controller

This block lets software reach the management registers of Ethernet PHYs over the two-wire MDC/MDIO bus. Software first loads a 16-bit data register when it wants to write. It then writes one packed control word that names a PHY, a register inside that PHY, and a read or write operation bit. The block serialises a full management frame on MDIO while generating MDC from the system clock. When the frame ends it clears the operation bit. For a read, it also deposits the 16 returned bits in the data register. Software finds completion by polling the same control word.

The frame is sequenced by a state machine with these states:

| State | Role | Next state |
|---|---|---|
| IDLE | Waits for work. | PREAMBLE once an operation bit is pending. |
| PREAMBLE | Sends 32 ones. | START |
| START | Sends 01. | OPCODE |
| OPCODE | Sends 10 for a read, 01 for a write. | PHYADR |
| PHYADR | Sends the 5-bit PHY address. | REGADR |
| REGADR | Sends the 5-bit register address. | TURN |
| TURN | Two turnaround bits. | DATA |
| DATA | Sixteen data bits. | DONE |
| DONE | Lasts one cycle; clears the operation bit and stores read data. | IDLE |

Each transition out of a timed state takes place on the falling MDC edge that ends that state's last bit.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Control word (reg_sel=0): PHY address in bits 13:9, register address in bits 8:4, read request in bit 0, write request in bit 1. Bits 15:14 and 3:2 read back as 0. A control write with neither request bit set starts no frame, and MDC stays low.
- R2: A frame is sent MSB first, in this order:
  - 32 ones;
  - start code 01;
  - opcode 10 (read) or 01 (write);
  - the 5-bit PHY address;
  - the 5-bit register address;
  - two turnaround bits, 10 on a write;
  - 16 data bits.
- R3: MDC is low while idle and has a period of 2*DIV_HALF system clocks during a frame. MDIO output changes only together with a falling MDC edge.
- R4: On a read, mdio_oe is low during the turnaround and data bits. The 16 bits sampled at the rising MDC edges of the data phase are stored MSB first in the data register (reg_sel=1).
- R5: The requested operation bit reads back as 1 from the write that sets it until the frame ends, and then reads 0, well within 4000 polls.
- R6: A write frame carries the data register contents, and the data register keeps that value after the write completes.
- R7: While an operation is in progress, writes to the control word and to the data register are ignored.
- R8: A control write with both request bits set performs a read only, and the control word then reads back with only bit 0 set.
- R9: When no PHY drives the line during a read (the line idles high), the read returns 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control word, 1 data register |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Writes and reads go to a PHY model that decodes each frame from the pins. Distinct data patterns (A5C3, 0001, 1010, 7809) separate a swapped or shifted data bit from a correct one. The address corners (register 0, register 31, an absent PHY) separate a misplaced address field from an undriven-line read. A read right after a write to the same register shows that the write frame reached the PHY intact. Control writes during a transfer, a write with both request bits set, and a write with no request bit set each exercise one rule of the control word.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_LEN = 32;
    localparam int FRAME_W = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int CNT_W   = $clog2(PRE_LEN + 1);

    localparam int CTL_RD      = 0;
    localparam int CTL_WR      = 1;
    localparam int CTL_REG_LSB = 4;
    localparam int CTL_PHY_LSB = 9;

    localparam logic [1:0] SOF_CODE  = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] TA_CODE   = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADR,
        ST_REGADR,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

    function automatic logic [CNT_W-1:0] phase_len(input mdio_state_e s);
        case (s)
            ST_PREAMBLE: return CNT_W'(PRE_LEN);
            ST_START:    return CNT_W'(2);
            ST_OPCODE:   return CNT_W'(2);
            ST_PHYADR:   return CNT_W'(PHY_W);
            ST_REGADR:   return CNT_W'(REG_W);
            ST_TURN:     return CNT_W'(2);
            ST_DATA:     return CNT_W'(DATA_W);
            default:     return CNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    logic tick;

    generate
        if (DIV_HALF == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(DIV_HALF);
            localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = run && (cnt_q == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            mdc <= 1'b0;
        end else if (tick) begin
            mdc <= ~mdc;
        end
    end

    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [PHY_W-1:0]  phy_adr,
    input  logic [REG_W-1:0]  reg_adr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              run,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output mdio_state_e       state
);
    mdio_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] frame_q;
    logic               rd_q;
    logic               phase_end;

    assign phase_end = fall_tick && (cnt_q == phase_len(state_q) - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)     state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (phase_end) state_d = ST_START;
            ST_START:    if (phase_end) state_d = ST_OPCODE;
            ST_OPCODE:   if (phase_end) state_d = ST_PHYADR;
            ST_PHYADR:   if (phase_end) state_d = ST_REGADR;
            ST_REGADR:   if (phase_end) state_d = ST_TURN;
            ST_TURN:     if (phase_end) state_d = ST_DATA;
            ST_DATA:     if (phase_end) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register and bit counter within the current phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (fall_tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // frame shifter and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            rd_q    <= 1'b0;
            rd_data <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                frame_q <= {{PRE_LEN{1'b1}}, SOF_CODE,
                            (is_read ? OPC_READ : OPC_WRITE),
                            phy_adr, reg_adr, TA_CODE,
                            (is_read ? {DATA_W{1'b0}} : wr_data)};
                rd_q    <= is_read;
            end else if (fall_tick) begin
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            end
            if (rise_tick && state_q == ST_DATA && rd_q) begin
                rd_data <= {rd_data[DATA_W-2:0], mdio_in};
            end
        end
    end

    // outputs
    always_comb begin
        run      = (state_q != ST_IDLE) && (state_q != ST_DONE);
        mdio_oe  = run && !(rd_q && (state_q == ST_TURN || state_q == ST_DATA));
        mdio_out = mdio_oe && frame_q[FRAME_W-1];
        done     = (state_q == ST_DONE);
        state    = state_q;
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  reg_q;
    logic              op_rd_q, op_wr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] ctrl_word;
    logic              busy, start;
    logic              run, rise_tick, fall_tick, fsm_done;
    logic [DATA_W-1:0] fsm_rdata;
    mdio_state_e       fsm_state;

    assign busy  = op_rd_q || op_wr_q;
    assign start = busy && (fsm_state == ST_IDLE);

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTL_PHY_LSB +: PHY_W] = phy_q;
        ctrl_word[CTL_REG_LSB +: REG_W] = reg_q;
        ctrl_word[CTL_RD]               = op_rd_q;
        ctrl_word[CTL_WR]               = op_wr_q;
    end

    assign reg_rdata = reg_sel ? data_q : ctrl_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q   <= '0;
            reg_q   <= '0;
            op_rd_q <= 1'b0;
            op_wr_q <= 1'b0;
            data_q  <= '0;
        end else if (fsm_done) begin
            op_rd_q <= 1'b0;
            op_wr_q <= 1'b0;
            if (op_rd_q) data_q <= fsm_rdata;
        end else if (reg_we && !busy) begin
            if (reg_sel) begin
                data_q <= reg_wdata;
            end else begin
                phy_q   <= reg_wdata[CTL_PHY_LSB +: PHY_W];
                reg_q   <= reg_wdata[CTL_REG_LSB +: REG_W];
                op_rd_q <= reg_wdata[CTL_RD];
                op_wr_q <= reg_wdata[CTL_WR] && !reg_wdata[CTL_RD];
            end
        end
    end

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_read   (op_rd_q),
        .phy_adr   (phy_q),
        .reg_adr   (reg_q),
        .wr_data   (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_i),
        .run       (run),
        .mdio_out  (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (fsm_done),
        .rd_data   (fsm_rdata),
        .state     (fsm_state)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
    import mdio_mgmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic [3:0] st,
    input logic [1:0] op_bits,
    input logic [9:0] fields
);
    p_mdio_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!mdc && !mdio_oe));

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bits == 2'b01 && (st == ST_TURN || st == ST_DATA)) |-> !mdio_oe);

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |=> (op_bits == 2'b00));

    p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bits != 2'b00 && $past(op_bits) != 2'b00) |-> $stable(fields));

    p_single_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_bits != 2'b11);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .st      (fsm_state),
    .op_bits ({op_wr_q, op_rd_q}),
    .fields  (ctrl_word[13:4])
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
    localparam int DIV_HALF = 2;
    localparam logic [4:0] PHY_ID = 5'd5;

    logic clk = 1'b0, rst_n = 1'b0, reg_sel = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic mdc, mdio_o, mdio_oe, mdio_i;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int vectors = 0, miscompares = 0;

    // PHY model: line idles high, one PHY answers at PHY_ID
    logic phy_drv = 1'b0, phy_val = 1'b0;
    int phy_bitn = 64;
    int mdc_rises = 0;
    int ta_oe_bad = 0;
    logic [63:0] seen = '0;
    logic [63:0] last_frame = '0;
    logic [15:0] phy_regs [32];
    event frame_ev;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    typedef struct packed {
        logic [63:0] bits;
        logic [63:0] mask;
    } frame_t;
    frame_t exp_q[$];
    frame_t mon_e;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge mdc) begin
        mdc_rises++;
        if (phy_bitn < 64) begin
            seen[63-phy_bitn] = mdio_i;
            if (phy_bitn >= 46 && seen[29:28] == 2'b10 && mdio_oe) ta_oe_bad++;
            if (phy_bitn == 63) begin
                if (seen[29:28] == 2'b01 && seen[27:23] == PHY_ID)
                    phy_regs[seen[22:18]] = seen[15:0];
                last_frame = seen;
                -> frame_ev;
            end
            phy_bitn++;
        end
    end

    always @(negedge mdc) begin
        if (phy_bitn >= 47 && phy_bitn <= 63 && seen[29:28] == 2'b10 &&
            seen[27:23] == PHY_ID) begin
            phy_drv = 1'b1;
            phy_val = (phy_bitn == 47) ? 1'b0 : phy_regs[seen[22:18]][63-phy_bitn];
        end else begin
            phy_drv = 1'b0;
        end
    end

    // scoreboard monitor: compare each finished frame with the queued item
    always begin
        @(frame_ev);
        if (exp_q.size() == 0) begin
            check("R2 unexpected frame", last_frame, 64'h0);
        end else begin
            mon_e = exp_q.pop_front();
            check("R2 frame bits", last_frame & mon_e.mask, mon_e.bits & mon_e.mask);
        end
    end

    function automatic frame_t mk_frame(bit rd, logic [4:0] phy, logic [4:0] rg,
                                        logic [15:0] d);
        frame_t f;
        f.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10,
                  (rd ? 16'h0 : d)};
        f.mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        return f;
    endfunction

    function automatic logic [15:0] ctl(logic [4:0] phy, logic [4:0] rg, bit rd, bit wr);
        return {2'b00, phy, rg, 2'b00, wr, rd};
    endfunction

    task automatic reg_write(bit sel, logic [15:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(bit sel, output logic [15:0] v);
        reg_sel = sel;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic start_op(bit rd, bit wr, logic [4:0] phy, logic [4:0] rg,
                            logic [15:0] d);
        exp_q.push_back(mk_frame(rd, phy, rg, d));
        phy_bitn = 0;
        reg_write(1'b0, ctl(phy, rg, rd, wr));
    endtask

    task automatic wait_done(string tag);
        int polls = 0;
        logic [15:0] v;
        reg_read(1'b0, v);
        while (v[1:0] != 2'b00 && polls < 4000) begin
            @(negedge clk);
            polls++;
            reg_read(1'b0, v);
        end
        check(tag, {62'h0, v[1:0]}, 64'h0);
    endtask

    task automatic do_read(logic [4:0] phy, logic [4:0] rg, logic [15:0] exp);
        logic [15:0] v;
        start_op(1'b1, 1'b0, phy, rg, 16'h0);
        reg_read(1'b0, v);
        check("R1 R5 control word while busy", v, ctl(phy, rg, 1'b1, 1'b0));
        wait_done("R5 read bit cleared");
        reg_read(1'b1, v);
        check("R4 read data", v, exp);
    endtask

    task automatic do_write(logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        logic [15:0] v;
        reg_write(1'b1, d);
        start_op(1'b0, 1'b1, phy, rg, d);
        reg_read(1'b0, v);
        check("R5 write bit set", v, ctl(phy, rg, 1'b0, 1'b1));
        wait_done("R5 write bit cleared");
        reg_read(1'b1, v);
        check("R6 data register kept", v, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] v;
        longint t0, t1;
        int r0;
        for (int i = 0; i < 32; i++) phy_regs[i] = 16'h1000 + 16'(i);
        phy_regs[0] = 16'h7809;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        reg_read(1'b0, v);
        check("R1 control after reset", v, 16'h0);
        reg_read(1'b1, v);
        check("R4 data after reset", v, 16'h0);
        check("R3 mdc idle low", {63'h0, mdc}, 64'h0);
        check("R3 oe idle low", {63'h0, mdio_oe}, 64'h0);

        // writes and reads with distinct patterns and address corners
        do_write(PHY_ID, 5'd3, 16'hA5C3);
        check("R6 PHY received data", phy_regs[3], 16'hA5C3);
        do_read(PHY_ID, 5'd3, 16'hA5C3);
        do_read(PHY_ID, 5'd0, 16'h7809);
        do_read(5'd7, 5'd0, 16'hFFFF);      // R9: nobody drives the line
        do_write(PHY_ID, 5'd31, 16'h0001);
        do_read(PHY_ID, 5'd31, 16'h0001);
        do_read(PHY_ID, 5'd16, 16'h1010);

        // R8: both request bits set behaves as a read
        exp_q.push_back(mk_frame(1'b1, PHY_ID, 5'd0, 16'h0));
        phy_bitn = 0;
        reg_write(1'b0, 16'h0A03);
        reg_read(1'b0, v);
        check("R8 only read bit kept", v, 16'h0A01);
        wait_done("R8 R5 op cleared");
        reg_read(1'b1, v);
        check("R8 read result", v, 16'h7809);

        // R7: writes ignored while busy; R3: MDC period
        reg_write(1'b1, 16'h1234);
        start_op(1'b0, 1'b1, PHY_ID, 5'd4, 16'h1234);
        @(posedge mdc); t0 = longint'($time);
        @(posedge mdc); t1 = longint'($time);
        check("R3 MDC period ns", 64'(t1 - t0), 64'(DIV_HALF * 10));
        reg_write(1'b0, ctl(5'd3, 5'd9, 1'b1, 1'b0));
        reg_write(1'b1, 16'hBEEF);
        reg_read(1'b0, v);
        check("R7 control write ignored", v, ctl(PHY_ID, 5'd4, 1'b0, 1'b1));
        wait_done("R7 R5 op cleared");
        reg_read(1'b1, v);
        check("R7 data write ignored", v, 16'h1234);
        check("R6 PHY received data", phy_regs[4], 16'h1234);

        // R1: no request bit, reserved bits read 0, no frame
        r0 = mdc_rises;
        reg_write(1'b0, 16'hC40C);
        reg_read(1'b0, v);
        check("R1 reserved bits zero", v, 16'h0400);
        repeat (40) @(negedge clk);
        check("R1 no frame started", 64'(mdc_rises), 64'(r0));

        check("R4 oe released in read turnaround and data", 64'(ta_oe_bad), 64'h0);
        check("R2 all frames seen", 64'(exp_q.size()), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule